// File: doc/BRIEF.md
# Sobel Frame Edge Filter

This block turns a grayscale frame held in a dual-port pixel memory into an edge-strength image. It runs after a one-cycle start pulse. The block reads each 8-bit pixel once, in raster order, one per clock. It keeps the two previous lines in internal line buffers, so it can form a sliding 3x3 neighbourhood. For each neighbourhood it computes a horizontal and a vertical gradient and the rounded-down Euclidean magnitude. It limits that magnitude to 8 bits and writes it to the address of the neighbourhood's centre pixel. A display reader can then fetch the finished image from the same memory.

The frame size is set by parameters, with a default of 160 columns by 120 lines. Both memory ports have a fixed latency and never stall, so neither data path has a ready or back-pressure signal. The read port returns data one cycle after the request, and the write port accepts one write in every cycle. Writes trail reads by a little more than one line. The result can therefore overwrite the source frame in place. Start and done are plain control pins.

Top module: `sobel_edge_engine`

## Requirements
- R1: A start pulse while idle makes the block assert rd_en for exactly W*H consecutive cycles, with rd_addr stepping 0, 1, 2 and upward. The pixel for each request is taken from rd_data in the following cycle.
- R2: Each pass produces exactly W*H writes. They occur one per cycle, in strictly ascending address order starting at 0, so every address below W*H is written exactly once.
- R3: A pixel in line 0, line H-1, column 0 or column W-1 is written as 0.
- R4: Every other pixel is written with floor(sqrt(gx*gx + gy*gy)). Here gx is the sum of the right column of its 3x3 neighbourhood, weighted 1, 2, 1 from top to bottom, minus the left column weighted the same way. gy is the top line weighted 1, 2, 1 from left to right, minus the bottom line weighted the same way.
- R5: A magnitude above 255 is written as 255.
- R6: done is high for one cycle only, in the cycle right after the cycle that carries the write to address W*H-1. No write occurs in the cycle after done.
- R7: A start pulse during a running pass has no effect. The pass keeps its read and write sequence and raises done only once.
- R8: A write never targets an address that has not been read yet. Using one memory as both source and destination therefore gives the same result as filtering an untouched copy.
- R9: While reset is low, rd_en, wr_en and done are low. A reset in the middle of a pass abandons it, and the next start runs a complete pass.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | One-cycle pulse that launches a pass when the block is idle |
| done | output | 1 | One-cycle pulse after the final result write |
| rd_en | output | 1 | Pixel read request |
| rd_addr | output | clog2(W*H) | Raster address of the requested pixel |
| rd_data | input | 8 | Pixel returned one cycle after rd_en |
| wr_en | output | 1 | Result write strobe |
| wr_addr | output | clog2(W*H) | Raster address of the result (the centre pixel) |
| wr_data | output | 8 | Clamped edge magnitude |

## Verification
The bench runs a small frame through the filter with several patterns:
- A flat field: every output must be zero, so a spurious bias in the arithmetic shows up.
- A vertical step and a horizontal step: each one excites only one gradient, so swapped or mis-signed kernels are exposed.
- A diagonal ramp: both gradients are non-zero and the square root of 8000 has a fractional part, which checks the combination and the rounding down.
- A full-swing step: its gradient of 1020 must saturate to 255.
- A checkerboard: the gradients cancel exactly, so a wrong tap alignment shows up.
- A scrambled pattern: compared pixel by pixel against an independent model, so a line buffer that is off by one line is caught.

// File: rtl/sobel_pkg.sv
package sobel_pkg;

  typedef enum logic [0:0] {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } run_state_e;

  // Travels beside a window position through the pipeline
  typedef struct packed {
    logic valid;     // a result write belongs to this slot
    logic interior;  // centre has a complete 3x3 neighbourhood
  } slot_tag_t;

endpackage

// File: rtl/sobel_addr_gen.sv
module sobel_addr_gen import sobel_pkg::*; #(
  parameter int IMG_W  = 160,
  parameter int IMG_H  = 120,
  parameter int ADDR_W = 15,
  parameter int COL_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  output logic              rd_en,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              s1_shift,
  output logic              s1_pix_ok,
  output logic [COL_W-1:0]  s1_col,
  output slot_tag_t         s1_tag,
  output logic [ADDR_W-1:0] s1_caddr
);
  localparam int NPIX  = IMG_W * IMG_H;
  localparam int LAST  = NPIX + IMG_W;    // flush runs on past the frame
  localparam int CNT_W = $clog2(LAST + 1);
  localparam int ROW_W = $clog2(IMG_H + 1);

  run_state_e       state;
  logic [CNT_W-1:0] k;
  logic [COL_W-1:0] col;
  logic [ROW_W-1:0] row;
  logic             in_frame, centre_ok, interior, running;

  assign running   = (state == ST_RUN);
  assign in_frame  = (k < CNT_W'(NPIX));
  assign centre_ok = (k >= CNT_W'(IMG_W + 1));
  assign interior  = in_frame && (row >= ROW_W'(2)) && (col >= COL_W'(2));
  assign rd_en     = running && in_frame;
  assign rd_addr   = k[ADDR_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      k         <= '0;
      col       <= '0;
      row       <= '0;
      s1_shift  <= 1'b0;
      s1_pix_ok <= 1'b0;
      s1_col    <= '0;
      s1_tag    <= '0;
      s1_caddr  <= '0;
    end else begin
      s1_shift        <= running;
      s1_pix_ok       <= rd_en;
      s1_col          <= col;
      s1_tag.valid    <= running && centre_ok;
      s1_tag.interior <= interior;
      s1_caddr        <= ADDR_W'(k - CNT_W'(IMG_W + 1));
      case (state)
        ST_IDLE: begin
          if (start) begin
            state <= ST_RUN;
            k     <= '0;
            col   <= '0;
            row   <= '0;
          end
        end
        ST_RUN: begin
          k <= k + 1'b1;
          if (col == COL_W'(IMG_W - 1)) begin
            col <= '0;
            row <= row + 1'b1;
          end else begin
            col <= col + 1'b1;
          end
          if (k == CNT_W'(LAST)) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R1: a pass opens its reads at address 0
  assert_rd_first_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_en) |-> (rd_addr == '0));

  // R1: back-to-back reads step by one address
  assert_rd_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && $past(rd_en)) |-> (rd_addr == $past(rd_addr) + 1'b1));

endmodule

// File: rtl/sobel_window.sv
module sobel_window #(
  parameter int IMG_W = 160,
  parameter int PIX_W = 8,
  parameter int COL_W = 8
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        shift,
  input  logic [COL_W-1:0]            col,
  input  logic [PIX_W-1:0]            pix,
  output logic [2:0][2:0][PIX_W-1:0]  win
);
  // line_q[0] holds the line above the incoming one, line_q[1] the one above that
  logic [PIX_W-1:0]       line_q [2][IMG_W];
  logic [2:0][PIX_W-1:0]  tap;

  always_comb begin
    tap[0] = line_q[1][col];
    tap[1] = line_q[0][col];
    tap[2] = pix;
  end

  always_ff @(posedge clk) begin
    if (shift) begin
      line_q[1][col] <= line_q[0][col];
      line_q[0][col] <= pix;
    end
  end

  // One shifting row of three taps per window line; column 2 is the newest
  for (genvar r = 0; r < 3; r++) begin : g_row
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        win[r] <= '0;
      end else if (shift) begin
        win[r][0] <= win[r][1];
        win[r][1] <= win[r][2];
        win[r][2] <= tap[r];
      end
    end
  end

endmodule

// File: rtl/sobel_grad.sv
module sobel_grad import sobel_pkg::*; #(
  parameter int PIX_W  = 8,
  parameter int ADDR_W = 15,
  parameter int NPIX   = 19200
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  slot_tag_t                  in_tag,
  input  logic [ADDR_W-1:0]          in_addr,
  input  logic [2:0][2:0][PIX_W-1:0] win,
  output logic                       wr_en,
  output logic [ADDR_W-1:0]          wr_addr,
  output logic [PIX_W-1:0]           wr_data
);
  localparam int GRAD_W = PIX_W + 3;          // signed, holds +/-1020
  localparam int MAG_W  = PIX_W + 2;          // |gradient|
  localparam int SQ_W   = 2 * MAG_W + 1;      // sum of two squares
  localparam int ROOT_W = (SQ_W + 1) / 2;
  localparam int SQ2_W  = 2 * ROOT_W;

  function automatic logic signed [GRAD_W-1:0] px(input logic [PIX_W-1:0] v);
    return $signed(GRAD_W'(v));
  endfunction

  function automatic logic [ROOT_W-1:0] isqrt(input logic [SQ_W-1:0] s);
    logic [ROOT_W-1:0] r, t;
    logic [SQ2_W-1:0]  sq;
    r = '0;
    for (int b = ROOT_W - 1; b >= 0; b--) begin
      t  = r | (ROOT_W'(1) << b);
      sq = t * t;
      if (sq <= SQ2_W'(s)) r = t;
    end
    return r;
  endfunction

  // Stage A: gradients and absolute values
  logic signed [GRAD_W-1:0] gx, gy;
  always_comb begin
    gx = (px(win[0][2]) + (px(win[1][2]) <<< 1) + px(win[2][2]))
       - (px(win[0][0]) + (px(win[1][0]) <<< 1) + px(win[2][0]));
    gy = (px(win[0][0]) + (px(win[0][1]) <<< 1) + px(win[0][2]))
       - (px(win[2][0]) + (px(win[2][1]) <<< 1) + px(win[2][2]));
  end

  slot_tag_t         a_tag, b_tag;
  logic [ADDR_W-1:0] a_addr, b_addr;
  logic [MAG_W-1:0]  ax, ay;
  logic [SQ_W-1:0]   b_sum;
  logic [2*MAG_W-1:0] sqx, sqy;
  logic [ROOT_W-1:0] root;
  logic [PIX_W-1:0]  clamped;

  always_comb begin
    sqx     = ax * ax;
    sqy     = ay * ay;
    root    = isqrt(b_sum);
    clamped = (root > ROOT_W'((1 << PIX_W) - 1)) ? '1 : root[PIX_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_tag   <= '0;
      a_addr  <= '0;
      ax      <= '0;
      ay      <= '0;
      b_tag   <= '0;
      b_addr  <= '0;
      b_sum   <= '0;
      wr_en   <= 1'b0;
      wr_addr <= '0;
      wr_data <= '0;
    end else begin
      a_tag   <= in_tag;
      a_addr  <= in_addr;
      ax      <= MAG_W'(gx[GRAD_W-1] ? -gx : gx);
      ay      <= MAG_W'(gy[GRAD_W-1] ? -gy : gy);
      b_tag   <= a_tag;
      b_addr  <= a_addr;
      b_sum   <= {1'b0, sqx} + {1'b0, sqy};
      wr_en   <= b_tag.valid;
      wr_addr <= b_addr;
      wr_data <= b_tag.interior ? clamped : '0;
    end
  end

  // R4: the root taken from the squared sum is its floor
  logic [SQ2_W+1:0] r_lo, r_hi;
  always_comb begin
    r_lo = root * root;
    r_hi = (root + 1'b1) * (root + 1'b1);
  end
  assert_root_floor_R4: assert property (@(posedge clk) disable iff (!rst_n)
    b_tag.valid |-> ((r_lo <= (SQ2_W+2)'(b_sum)) && (r_hi > (SQ2_W+2)'(b_sum))));

  // R2: writes stay inside the frame and advance by one address
  assert_wr_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (int'(wr_addr) < NPIX));
  assert_wr_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && $past(wr_en)) |-> (wr_addr == $past(wr_addr) + 1'b1));

endmodule

// File: rtl/sobel_edge_engine.sv
module sobel_edge_engine import sobel_pkg::*; #(
  parameter  int IMG_W  = 160,
  parameter  int IMG_H  = 120,
  parameter  int PIX_W  = 8,
  localparam int ADDR_W = $clog2(IMG_W * IMG_H)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  output logic              done,
  output logic              rd_en,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic [PIX_W-1:0]  rd_data,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [PIX_W-1:0]  wr_data
);
  localparam int NPIX  = IMG_W * IMG_H;
  localparam int COL_W = $clog2(IMG_W);

  logic                       s1_shift, s1_pix_ok;
  logic [COL_W-1:0]           s1_col;
  slot_tag_t                  s1_tag, s2_tag;
  logic [ADDR_W-1:0]          s1_caddr, s2_caddr;
  logic [PIX_W-1:0]           pix_in;
  logic [2:0][2:0][PIX_W-1:0] win;

  sobel_addr_gen #(
    .IMG_W(IMG_W), .IMG_H(IMG_H), .ADDR_W(ADDR_W), .COL_W(COL_W)
  ) u_addr (
    .clk(clk), .rst_n(rst_n), .start(start),
    .rd_en(rd_en), .rd_addr(rd_addr),
    .s1_shift(s1_shift), .s1_pix_ok(s1_pix_ok), .s1_col(s1_col),
    .s1_tag(s1_tag), .s1_caddr(s1_caddr)
  );

  assign pix_in = s1_pix_ok ? rd_data : '0;

  sobel_window #(
    .IMG_W(IMG_W), .PIX_W(PIX_W), .COL_W(COL_W)
  ) u_win (
    .clk(clk), .rst_n(rst_n), .shift(s1_shift), .col(s1_col),
    .pix(pix_in), .win(win)
  );

  // Tag rides alongside the window update
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s2_tag   <= '0;
      s2_caddr <= '0;
    end else begin
      s2_tag   <= s1_tag;
      s2_caddr <= s1_caddr;
    end
  end

  sobel_grad #(
    .PIX_W(PIX_W), .ADDR_W(ADDR_W), .NPIX(NPIX)
  ) u_grad (
    .clk(clk), .rst_n(rst_n), .in_tag(s2_tag), .in_addr(s2_caddr), .win(win),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) done <= 1'b0;
    else        done <= wr_en && (wr_addr == ADDR_W'(NPIX - 1));
  end

  // R6: done lasts one cycle and is not followed by a write
  assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_quiet_after_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !wr_en);

  // R8: a write always lags the read pointer
  assert_wr_behind_rd_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && rd_en) |-> (wr_addr < rd_addr));

endmodule

// File: tb/tb_sobel_edge_engine.sv
module tb_sobel_edge_engine;
  localparam int TW = 8;
  localparam int TH = 6;
  localparam int N  = TW * TH;
  localparam int AW = $clog2(N);

  // pattern id, expected value at line 2 column 3 (-1: none), stray start
  localparam int VEC [7][3] = '{
    '{0,   0, 0},
    '{1,  80, 1},
    '{2, 240, 0},
    '{3,  89, 0},
    '{4, 255, 0},
    '{5,   0, 0},
    '{6,  -1, 0}
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic          done, rd_en, wr_en;
  logic [AW-1:0] rd_addr, wr_addr;
  logic [7:0]    rd_data = 8'd0;
  logic [7:0]    wr_data;

  logic [7:0] mem  [N];
  int         orig [N];

  int checks = 0, errors = 0;
  int cyc = 0, rd_cnt = 0, rd_bad = 0, wr_cnt = 0, wr_bad = 0;
  int done_cnt = 0, done_cyc = -1, last_wr = -1;

  always #10 clk = ~clk;

  sobel_edge_engine #(.IMG_W(TW), .IMG_H(TH)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .done(done),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data)
  );

  // Dual-port frame memory, one-cycle read latency
  always @(posedge clk) begin
    if (rd_en) rd_data <= mem[rd_addr];
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      if (rd_en) begin
        if (int'(rd_addr) != rd_cnt) rd_bad++;
        rd_cnt++;
      end
      if (wr_en) begin
        if (int'(wr_addr) != wr_cnt) wr_bad++;
        wr_cnt++;
        last_wr = cyc;
      end
      if (done) begin
        done_cnt++;
        done_cyc = cyc;
      end
    end
  end

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  always @(negedge clk) begin
    if (cyc > 20000) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      summary();
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int pattern(int p, int r, int c);
    case (p)
      0: return 100;
      1: return (c >= 4) ? 60 : 40;
      2: return (r >= 3) ? 70 : 10;
      3: return 10 * r + 5 * c;
      4: return (c >= 4) ? 255 : 0;
      5: return ((r + c) % 2 == 1) ? 255 : 0;
      default: return (r * 37 + c * 91 + r * c * 13) % 256;
    endcase
  endfunction

  function automatic int o(int r, int c);
    return orig[r * TW + c];
  endfunction

  function automatic int model(int r, int c);
    int gx, gy, s, m;
    if (r == 0 || r == TH - 1 || c == 0 || c == TW - 1) return 0;
    gx = (o(r-1,c+1) + 2*o(r,c+1) + o(r+1,c+1)) - (o(r-1,c-1) + 2*o(r,c-1) + o(r+1,c-1));
    gy = (o(r-1,c-1) + 2*o(r-1,c) + o(r-1,c+1)) - (o(r+1,c-1) + 2*o(r+1,c) + o(r+1,c+1));
    s = gx * gx + gy * gy;
    m = 0;
    while ((m + 1) * (m + 1) <= s) m++;
    return (m > 255) ? 255 : m;
  endfunction

  task automatic run_pass(input int pat, input int probe, input int stray);
    int waited;
    int e;
    for (int r = 0; r < TH; r++)
      for (int c = 0; c < TW; c++) begin
        orig[r*TW + c] = pattern(pat, r, c);
        mem[r*TW + c]  = 8'(pattern(pat, r, c));
      end
    @(negedge clk);
    rd_cnt = 0; rd_bad = 0; wr_cnt = 0; wr_bad = 0;
    done_cnt = 0; done_cyc = -1; last_wr = -1;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (stray != 0) begin
      repeat (20) @(negedge clk);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    waited = 0;
    while (done_cnt == 0 && waited < 500) begin
      @(negedge clk);
      waited++;
    end
    repeat (6) @(negedge clk);
    check(rd_cnt == N, "R1 read count", rd_cnt, N);
    check(rd_bad == 0, "R1 read address order", rd_bad, 0);
    check(wr_cnt == N, "R2 write count", wr_cnt, N);
    check(wr_bad == 0, "R2 write address order", wr_bad, 0);
    check(done_cnt == 1, "R6 done pulses", done_cnt, 1);
    check(done_cyc == last_wr + 1, "R6 done after last write", done_cyc, last_wr + 1);
    if (stray != 0)
      check(rd_bad == 0 && wr_cnt == N && done_cnt == 1,
            "R7 stray start ignored", wr_cnt, N);
    for (int r = 0; r < TH; r++)
      for (int c = 0; c < TW; c++) begin
        e = model(r, c);
        if (r == 0 || r == TH - 1 || c == 0 || c == TW - 1)
          check(int'(mem[r*TW + c]) == e, "R3 border zero", int'(mem[r*TW + c]), e);
        else if (e == 255)
          check(int'(mem[r*TW + c]) == e, "R5 saturate", int'(mem[r*TW + c]), e);
        else
          check(int'(mem[r*TW + c]) == e, "R4 R8 interior in place", int'(mem[r*TW + c]), e);
      end
    if (probe >= 0)
      check(int'(mem[2*TW + 3]) == probe, "R4 probe at line 2 col 3",
            int'(mem[2*TW + 3]), probe);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(!rd_en && !wr_en && !done, "R9 outputs low in reset",
          int'({rd_en, wr_en, done}), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(!rd_en && !wr_en && !done, "R9 idle after reset",
          int'({rd_en, wr_en, done}), 0);

    for (int i = 0; i < 7; i++)
      run_pass(VEC[i][0], VEC[i][1], VEC[i][2]);

    // Reset in the middle of a pass, then a complete pass again
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (30) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check(!rd_en && !wr_en && !done, "R9 reset aborts pass",
          int'({rd_en, wr_en, done}), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(!rd_en && !wr_en, "R9 stays idle after abort", int'({rd_en, wr_en}), 0);
    run_pass(3, 89, 0);

    summary();
  end

endmodule